// File: doc/BRIEF.md
# Dual-Domain Reset Sequencer

This block generates two active-low resets for logic clocked by one system clock. The first reset serves the main logic: the processor, the bus and the user module. The second serves the debug logic. Three inputs drive the block. The first is an external active-low reset request. The second is a lock flag from the clock generator. The third is an active-high request from the debug logic to reset everything except itself. That third request is synchronous to the system clock.

Each output drops asynchronously as soon as any of its causes becomes active. It rises again only after its causes have stayed inactive through a chain of flops clocked by the system clock. Both outputs power up asserted, before any clock edge. The debug output ignores the debug logic's own reset request, so the debug logic stays alive while it resets the rest of the system.

Top module: `rst_seq`

## Requirements
- R1: `sys_rst_n` is 0 whenever `ext_rst_n` is 0 or `clk_locked` is 0. It falls in the same instant, without waiting for a clock edge.
- R2: `dbg_rst_n` is 0 whenever `ext_rst_n` is 0 or `clk_locked` is 0. It falls in the same instant, without waiting for a clock edge.
- R3: Raising `sysrst_req` (active high) drives `sys_rst_n` to 0 at once, and it stays 0 while `sysrst_req` is 1.
- R4: `sysrst_req` never changes `dbg_rst_n`.
- R5: An output returns to 1 on the STAGES-th rising edge (default 2) at which all its causes have been inactive without a break. It is never released earlier.
- R6: Both outputs are 0 from time zero, before the first clock edge.
- R7: Whenever `sys_rst_n` is 1, `dbg_rst_n` is also 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| ext_rst_n | input | 1 | External reset request, active low, asynchronous |
| clk_locked | input | 1 | Clock generator lock flag, 1 = locked |
| sysrst_req | input | 1 | Debug-side request to reset the main logic, active high, synchronous to clk |
| sys_rst_n | output | 1 | Reset for the main logic, active low |
| dbg_rst_n | output | 1 | Reset for the debug logic, active low |

## Verification
The assertions sample at rising edges. They assume that every input is stable around an edge and changes at most once between two edges. A cause that appears and disappears between two edges would therefore not be seen. The stimulus changes inputs only 1 ns after a rising edge and holds them there. This covers both the synchronous request and the asynchronous external reset and lock flag. The bench computes a saturating count of clean edges for each output, and the sweep walks all eight input combinations from both the settled and the partly released state.

// File: rtl/rst_seq.sv
module rst_seq #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic ext_rst_n,
  input  logic clk_locked,
  input  logic sysrst_req,
  output logic sys_rst_n,
  output logic dbg_rst_n
);

  logic dbg_clr_n;
  logic sys_clr_n;
  logic [STAGES-1:0] dbg_sync = '0;
  logic [STAGES-1:0] sys_sync = '0;

  assign dbg_clr_n = ext_rst_n & clk_locked;
  assign sys_clr_n = dbg_clr_n & ~sysrst_req;

  always_ff @(posedge clk or negedge dbg_clr_n)
    if (!dbg_clr_n) dbg_sync <= '0;
    else            dbg_sync <= {dbg_sync[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge sys_clr_n)
    if (!sys_clr_n) sys_sync <= '0;
    else            sys_sync <= {sys_sync[STAGES-2:0], 1'b1};

  assign dbg_rst_n = dbg_sync[STAGES-1];
  assign sys_rst_n = sys_sync[STAGES-1];

endmodule

module rst_seq_chk (
  input logic clk,
  input logic ext_rst_n,
  input logic clk_locked,
  input logic sysrst_req,
  input logic sys_rst_n,
  input logic dbg_rst_n
);
  logic dbg_ok, sys_ok;
  assign dbg_ok = ext_rst_n && clk_locked;
  assign sys_ok = dbg_ok && !sysrst_req;

  AST_SYS_HELD: assert property (@(posedge clk) disable iff (1'b0)
    !dbg_ok |-> !sys_rst_n); // R1
  AST_DBG_HELD: assert property (@(posedge clk) disable iff (1'b0)
    !dbg_ok |-> !dbg_rst_n); // R2
  AST_REQ_HOLDS_SYS: assert property (@(posedge clk) disable iff (!dbg_ok)
    sysrst_req |-> !sys_rst_n); // R3
  AST_DBG_IMMUNE: assert property (@(posedge clk) disable iff (!ext_rst_n || !clk_locked)
    dbg_rst_n |=> dbg_rst_n); // R4
  AST_SYS_LATE_RELEASE: assert property (@(posedge clk) disable iff (1'b0)
    sys_rst_n |-> ($past(sys_ok) && $past(sys_ok, 2))); // R5
  AST_DBG_LATE_RELEASE: assert property (@(posedge clk) disable iff (1'b0)
    dbg_rst_n |-> ($past(dbg_ok) && $past(dbg_ok, 2))); // R5
  AST_ORDER: assert property (@(posedge clk) disable iff (1'b0)
    sys_rst_n |-> dbg_rst_n); // R7
endmodule

bind rst_seq rst_seq_chk u_chk (
  .clk(clk), .ext_rst_n(ext_rst_n), .clk_locked(clk_locked),
  .sysrst_req(sysrst_req), .sys_rst_n(sys_rst_n), .dbg_rst_n(dbg_rst_n)
);

// File: tb/rst_seq_tb.sv
`timescale 1ns/1ps
module rst_seq_tb;
  localparam int STAGES = 2;

  logic clk = 1'b0;
  logic ext_rst_n = 1'b0;
  logic clk_locked = 1'b0;
  logic sysrst_req = 1'b0;
  logic sys_rst_n, dbg_rst_n;

  int n_chk = 0;
  int n_bad = 0;
  int cnt_sys = 0;
  int cnt_dbg = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  rst_seq #(.STAGES(STAGES)) u_dut (
    .clk(clk), .ext_rst_n(ext_rst_n), .clk_locked(clk_locked),
    .sysrst_req(sysrst_req), .sys_rst_n(sys_rst_n), .dbg_rst_n(dbg_rst_n)
  );

  function automatic bit ok_d();
    return ext_rst_n && clk_locked;
  endfunction
  function automatic bit ok_s();
    return ext_rst_n && clk_locked && !sysrst_req;
  endfunction

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic chk_model(input string tag);
    chk({tag, " sys"}, sys_rst_n, logic'(cnt_sys >= STAGES));
    chk({tag, " dbg"}, dbg_rst_n, logic'(cnt_dbg >= STAGES));
    if (sys_rst_n === 1'b1) chk("R7 sys up implies dbg up", dbg_rst_n, 1'b1);
  endtask

  task automatic edge_step(input string tag);
    @(posedge clk);
    cnt_sys = ok_s() ? ((cnt_sys < STAGES) ? cnt_sys + 1 : STAGES) : 0;
    cnt_dbg = ok_d() ? ((cnt_dbg < STAGES) ? cnt_dbg + 1 : STAGES) : 0;
    #1;
    chk_model(tag);
  endtask

  task automatic set_in(input logic e, input logic l, input logic r, input string tag);
    ext_rst_n = e; clk_locked = l; sysrst_req = r;
    if (!ok_s()) cnt_sys = 0;
    if (!ok_d()) cnt_dbg = 0;
    #0.5;
    chk_model(tag);
  endtask

  initial begin
    #1;
    chk("R6 sys at power-up", sys_rst_n, 1'b0);
    chk("R6 dbg at power-up", dbg_rst_n, 1'b0);
    for (int i = 0; i < 4; i++) edge_step("R1/R2 ext held");
    set_in(1'b0, 1'b1, 1'b0, "R1/R2 locked ext low");
    for (int i = 0; i < 3; i++) edge_step("R1/R2 ext low locked");
    set_in(1'b1, 1'b1, 1'b0, "R5 release start");
    edge_step("R5 first edge");
    chk("R5 sys not early", sys_rst_n, 1'b0);
    edge_step("R5 second edge");
    chk("R5 sys released", sys_rst_n, 1'b1);
    chk("R5 dbg released", dbg_rst_n, 1'b1);
    set_in(1'b1, 1'b0, 1'b0, "R1/R2 lock loss");
    chk("R1 sys on lock loss", sys_rst_n, 1'b0);
    chk("R2 dbg on lock loss", dbg_rst_n, 1'b0);
    edge_step("R1/R2 unlocked");
    set_in(1'b1, 1'b1, 1'b0, "R5 relock");
    edge_step("R5 relock edge 1");
    chk("R5 dbg not early after relock", dbg_rst_n, 1'b0);
    edge_step("R5 relock edge 2");
    for (int k = 1; k <= 3; k++) begin
      set_in(1'b1, 1'b1, 1'b1, "R3 request on");
      chk("R3 sys drops on request", sys_rst_n, 1'b0);
      chk("R4 dbg kept on request", dbg_rst_n, 1'b1);
      for (int j = 0; j < k; j++) begin
        edge_step("R3 request held");
        chk("R4 dbg during request", dbg_rst_n, 1'b1);
      end
      set_in(1'b1, 1'b1, 1'b0, "R4 request off");
      chk("R4 dbg after request", dbg_rst_n, 1'b1);
      for (int j = 0; j < 3; j++) edge_step("R5 after request");
    end
    for (int p = 0; p < 8; p++)
      for (int q = 0; q < 8; q++)
        for (int h = 1; h <= 3; h++) begin
          set_in(p[2], p[1], p[0], "R1-sweep from");
          for (int j = 0; j < 3; j++) edge_step("R5 sweep settle");
          set_in(q[2], q[1], q[0], "R1 sweep to");
          for (int j = 0; j < h; j++) edge_step("R2 sweep hold");
        end
    done = 1;
  end

  initial begin
    fork
      wait (done);
      #200000;
    join_any
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule